// File: doc/BRIEF.md
# EX-Stage Operand Bypass Selector

This block sits in front of the execute-stage ALU of a five-stage in-order pipeline. For each of the two ALU operands it decides where the value comes from. The first choice is the register-file value that the decode stage latched. The second is the result of the instruction one stage ahead, now in the memory stage. The third is the value that the instruction two stages ahead is about to write back. The block is purely combinational, and it returns both the 2-bit source selects and the two selected operands.

Operand A is looked up by the first source register number of the instruction in execute, and operand B by the second. A later stage only supplies a value if it will really write a register, and if its destination is not register 0, which is hard-wired to zero. When both later stages target the register an operand needs, the younger result from the memory stage wins, so a run of writes to one register always delivers its newest value. The write-back candidate is built inside the block: a flag picks between loaded memory data and the ALU result carried to write-back. Stall and load-use detection belong to other logic.

The house state-machine style does not apply here, because the block holds no state. Its select encoding plays the part of the named cases: `FWD_RF` (00), `FWD_WBK` (01), `FWD_EXM` (10), and the reserved `FWD_RSVD` (11).

Top module: `ex_operand_bypass`

## Requirements
- R1: When neither later stage matches an operand's source register, that operand's select is 2'b00 and the operand equals its register-file input.
- R2: When the memory-stage write enable is 1, its destination is nonzero and it equals the operand's source register, the select is 2'b10 and the operand equals the memory-stage result.
- R3: When the write-back-stage write enable is 1, its destination is nonzero and equals the source register, and R2's condition does not hold for that operand, the select is 2'b01 and the operand equals the write-back value.
- R4: When both later stages match the same source register, the memory-stage result is chosen (select 2'b10).
- R5: A destination of register 0 never causes forwarding from either stage, even when the source register is also 0.
- R6: A stage whose write enable is 0 never forwards, even with a matching destination. If the memory stage is disabled, a matching write-back stage still forwards.
- R7: The write-back value is the load data when the from-memory flag is 1, and the write-back ALU data when it is 0.
- R8: Operand A compares only its source register A and operand B only its source register B. The two resolve independently and may forward from the same stage at once.
- R9: A select output never takes the reserved code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_reg | input | 5 | Source register number for operand A (instruction in EX) |
| src_b_reg | input | 5 | Source register number for operand B (instruction in EX) |
| rf_a_data | input | 32 | Register-file value latched for operand A |
| rf_b_data | input | 32 | Register-file value latched for operand B |
| exm_wr_en | input | 1 | Memory-stage instruction will write a register |
| exm_dst_reg | input | 5 | Memory-stage destination register number |
| exm_result | input | 32 | Memory-stage ALU result |
| wbk_wr_en | input | 1 | Write-back-stage instruction will write a register |
| wbk_dst_reg | input | 5 | Write-back-stage destination register number |
| wbk_load_data | input | 32 | Data read from memory, at write-back |
| wbk_alu_data | input | 32 | ALU result carried to write-back |
| wbk_from_mem | input | 1 | 1 selects load data as the write-back value |
| sel_a | output | 2 | Source select for operand A |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench goes after the double-hit case: a chain of writes to one register. If the priority were inverted, operand values would be one write stale. It drives register-0 destinations with a source of 0, where a missing zero guard would forward a nonzero result in place of the hard-wired zero. It also drives matching destinations with their write enables cleared, where a missing enable check would pick up garbage from a store or a branch. Random register numbers drawn from a small range make matches on A and B at the same time common, to catch crossed source comparisons. Both settings of the from-memory flag are driven, to catch a write-back mux with its inputs reversed.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        FWD_RF   = 2'b00,
        FWD_WBK  = 2'b01,
        FWD_EXM  = 2'b10,
        FWD_RSVD = 2'b11
    } fwd_sel_e;

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src_reg,
    input  logic             wr_en,
    input  logic [REG_W-1:0] dst_reg,
    output logic             hit
);

    logic dst_live;

    assign dst_live = wr_en && (dst_reg != '0);
    assign hit      = dst_live && (dst_reg == src_reg);

endmodule

// File: rtl/fwd_priority.sv
module fwd_priority
    import fwd_pkg::*;
(
    input  logic     exm_hit,
    input  logic     wbk_hit,
    output fwd_sel_e sel
);

    always_comb begin
        unique case ({exm_hit, wbk_hit})
            2'b10, 2'b11: sel = FWD_EXM;
            2'b01:        sel = FWD_WBK;
            default:      sel = FWD_RF;
        endcase
        // R9: the reserved code never leaves the priority stage
        a_r9_sel_legal: assert (sel != FWD_RSVD);
        // R4: a memory-stage hit dominates regardless of write-back
        a_r4_exm_wins: assert (!exm_hit || sel == FWD_EXM);
        // R1: no hit selects the register file
        a_r1_idle_rf: assert (exm_hit || wbk_hit || sel == FWD_RF);
    end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_data,
    input  logic [DATA_W-1:0] exm_data,
    input  logic [DATA_W-1:0] wbk_data,
    output logic [DATA_W-1:0] opnd
);

    always_comb begin
        unique case (sel)
            FWD_EXM: opnd = exm_data;
            FWD_WBK: opnd = wbk_data;
            default: opnd = rf_data;
        endcase
        // R2: memory-stage select delivers the memory-stage result
        a_r2_exm_path: assert (sel != FWD_EXM || opnd == exm_data);
        // R3: write-back select delivers the write-back value
        a_r3_wbk_path: assert (sel != FWD_WBK || opnd == wbk_data);
    end

endmodule

// File: rtl/ex_operand_bypass.sv
module ex_operand_bypass
    import fwd_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic [REG_W-1:0]  src_a_reg,
    input  logic [REG_W-1:0]  src_b_reg,
    input  logic [DATA_W-1:0] rf_a_data,
    input  logic [DATA_W-1:0] rf_b_data,
    input  logic              exm_wr_en,
    input  logic [REG_W-1:0]  exm_dst_reg,
    input  logic [DATA_W-1:0] exm_result,
    input  logic              wbk_wr_en,
    input  logic [REG_W-1:0]  wbk_dst_reg,
    input  logic [DATA_W-1:0] wbk_load_data,
    input  logic [DATA_W-1:0] wbk_alu_data,
    input  logic              wbk_from_mem,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int NUM_OPND = 2;

    logic [DATA_W-1:0] wbk_value;
    logic [REG_W-1:0]  lane_src  [NUM_OPND];
    logic [DATA_W-1:0] lane_rf   [NUM_OPND];
    logic [DATA_W-1:0] lane_opnd [NUM_OPND];
    fwd_sel_e          lane_sel  [NUM_OPND];
    logic              lane_exm_hit [NUM_OPND];
    logic              lane_wbk_hit [NUM_OPND];

    // R7: write-back value picks loaded data or the ALU result
    assign wbk_value = wbk_from_mem ? wbk_load_data : wbk_alu_data;

    assign lane_src[0] = src_a_reg;
    assign lane_src[1] = src_b_reg;
    assign lane_rf[0]  = rf_a_data;
    assign lane_rf[1]  = rf_b_data;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_lane
        fwd_stage_match #(.REG_W(REG_W)) u_exm_match (
            .src_reg (lane_src[g]),
            .wr_en   (exm_wr_en),
            .dst_reg (exm_dst_reg),
            .hit     (lane_exm_hit[g])
        );

        fwd_stage_match #(.REG_W(REG_W)) u_wbk_match (
            .src_reg (lane_src[g]),
            .wr_en   (wbk_wr_en),
            .dst_reg (wbk_dst_reg),
            .hit     (lane_wbk_hit[g])
        );

        fwd_priority u_prio (
            .exm_hit (lane_exm_hit[g]),
            .wbk_hit (lane_wbk_hit[g]),
            .sel     (lane_sel[g])
        );

        fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel      (lane_sel[g]),
            .rf_data  (lane_rf[g]),
            .exm_data (exm_result),
            .wbk_data (wbk_value),
            .opnd     (lane_opnd[g])
        );
    end

    assign sel_a  = lane_sel[0];
    assign sel_b  = lane_sel[1];
    assign opnd_a = lane_opnd[0];
    assign opnd_b = lane_opnd[1];

    always_comb begin
        // R5: register 0 is never bypassed on either operand
        a_r5_zero_a: assert (src_a_reg != '0 || sel_a == 2'b00);
        a_r5_zero_b: assert (src_b_reg != '0 || sel_b == 2'b00);
        // R6: a disabled stage never supplies an operand
        a_r6_exm_en: assert (exm_wr_en || (sel_a != 2'b10 && sel_b != 2'b10));
        a_r6_wbk_en: assert (wbk_wr_en || (sel_a != 2'b01 && sel_b != 2'b01));
    end

endmodule

// File: tb/test_ex_operand_bypass.sv
module test_ex_operand_bypass;

    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  src_a_reg, src_b_reg, exm_dst_reg, wbk_dst_reg;
    logic [31:0] rf_a_data, rf_b_data, exm_result, wbk_load_data, wbk_alu_data;
    logic        exm_wr_en, wbk_wr_en, wbk_from_mem;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    ex_operand_bypass i_ex_operand_bypass (
        .src_a_reg, .src_b_reg, .rf_a_data, .rf_b_data,
        .exm_wr_en, .exm_dst_reg, .exm_result,
        .wbk_wr_en, .wbk_dst_reg, .wbk_load_data, .wbk_alu_data, .wbk_from_mem,
        .sel_a, .sel_b, .opnd_a, .opnd_b
    );

    // behavioural reference: which source does register r come from?
    function automatic int ref_sel(input int r);
        if (exm_wr_en && exm_dst_reg != 0 && int'(exm_dst_reg) == r) return 2;
        if (wbk_wr_en && wbk_dst_reg != 0 && int'(wbk_dst_reg) == r) return 1;
        return 0;
    endfunction

    function automatic string ref_tag(input int r);
        bit eh = exm_wr_en && exm_dst_reg != 0 && int'(exm_dst_reg) == r;
        bit wh = wbk_wr_en && wbk_dst_reg != 0 && int'(wbk_dst_reg) == r;
        if (eh && wh) return "R4";
        if (eh) return "R2";
        if (wh) return "R3";
        if (r == 0 && ((exm_dst_reg == 0 && exm_wr_en) || (wbk_dst_reg == 0 && wbk_wr_en))) return "R5";
        if ((!exm_wr_en && int'(exm_dst_reg) == r) || (!wbk_wr_en && int'(wbk_dst_reg) == r)) return "R6";
        return "R1";
    endfunction

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare all outputs against the reference, away from the edge
    task automatic compare(input string force_tag);
        int    sa, sb;
        longint wv, ea, eb;
        string ta, tb;
        @(negedge clk);
        sa = ref_sel(int'(src_a_reg));
        sb = ref_sel(int'(src_b_reg));
        wv = wbk_from_mem ? wbk_load_data : wbk_alu_data;
        ea = (sa == 2) ? exm_result : (sa == 1) ? wv : rf_a_data;
        eb = (sb == 2) ? exm_result : (sb == 1) ? wv : rf_b_data;
        ta = (force_tag != "") ? force_tag : ref_tag(int'(src_a_reg));
        tb = (force_tag != "") ? force_tag : ref_tag(int'(src_b_reg));
        chk(ta, "sel_a", sel_a, sa);
        chk(tb, "sel_b", sel_b, sb);
        chk(ta, "opnd_a", opnd_a, ea);
        chk(tb, "opnd_b", opnd_b, eb);
        chk("R9", "sel_a_not_rsvd", (sel_a == 2'b11), 0);
        chk("R9", "sel_b_not_rsvd", (sel_b == 2'b11), 0);
    endtask

    task automatic drive(input int ra, input int rb, input bit ew, input int ed,
                         input bit ww, input int wd, input bit fm);
        @(posedge clk);
        #1;
        src_a_reg = 5'(ra); src_b_reg = 5'(rb);
        exm_wr_en = ew; exm_dst_reg = 5'(ed);
        wbk_wr_en = ww; wbk_dst_reg = 5'(wd);
        wbk_from_mem = fm;
        rf_a_data = 32'hA000_0000 | 32'(ra);
        rf_b_data = 32'hB000_0000 | 32'(rb);
        exm_result = 32'hE111_0000 | 32'(ed);
        wbk_load_data = 32'h10AD_0000 | 32'(wd);
        wbk_alu_data  = 32'h0A1B_0000 | 32'(wd);
    endtask

    initial begin
        src_a_reg = 0; src_b_reg = 0; exm_wr_en = 0; exm_dst_reg = 0;
        wbk_wr_en = 0; wbk_dst_reg = 0; wbk_from_mem = 0;
        rf_a_data = 0; rf_b_data = 0; exm_result = 0;
        wbk_load_data = 0; wbk_alu_data = 0;
        repeat (3) @(posedge clk);
        rst = 0;
        // reset-time quiet inputs: R1
        compare("R1");
        drive(3, 4, 1, 7, 1, 8, 0);   compare("R1");
        drive(3, 4, 1, 3, 0, 0, 0);   compare("");   // R2 on A
        drive(3, 4, 0, 0, 1, 4, 1);   compare("");   // R3 on B, load data R7
        drive(3, 4, 0, 0, 1, 4, 0);   compare("R7");
        drive(5, 5, 1, 5, 1, 5, 1);   compare("R4");
        drive(0, 0, 1, 0, 1, 0, 0);   compare("R5");
        drive(6, 6, 0, 6, 0, 6, 0);   compare("R6");
        drive(6, 9, 0, 6, 1, 6, 1);   compare("R6");
        drive(2, 9, 1, 2, 1, 9, 0);   compare("R8");
        drive(9, 2, 1, 2, 1, 9, 1);   compare("R8");
        drive(31, 31, 1, 31, 0, 0, 0); compare("R2");
        for (int i = 0; i < 600; i++) begin
            drive($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                  $urandom_range(0, 3), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                  1'($urandom_range(0, 1)));
            compare("");
        end
        done = 1;
    end

    initial begin
        while (!done && cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule